// File: doc/BRIEF.md
# Serial Flash Erase Command Target

This block is the device-side command logic of a serial flash memory, limited to erasing. It listens on a four-wire SPI slave port, decodes a small command set (write enable, sector erase, bulk erase, status read) and, once a valid erase is accepted, runs an internally timed erase operation. It drives a request toward an abstract memory array that holds a sector index, a whole-array flag, a busy level and a one-cycle completion pulse. During that request the array sets every bit of the selected range to 1.

The SPI pins are sampled by the system clock through two-stage synchronizers, so the serial clock must run well below the system clock. An erase only takes effect when chip select is released exactly on the byte boundary that ends a complete frame. It also needs the write-enable latch to be set, no erase to be running, and a target that the block-protect level leaves open. The protect level comes in as a three-bit configuration input and is reported in the status byte.

Top module: `fe_erase_target`

## Requirements
- R1: After reset, erase_busy, erase_done and spi_so_oe are 0, and the status byte reads 0x00 when prot_level is 0.
- R2: A one-byte frame holding opcode 0x06, closed on the byte boundary while no erase runs, sets the write-enable latch (status bit 1).
- R3: Opcode 0x05 returns the status byte MSB first: bit 0 is the write-in-progress flag, bit 1 is the write-enable latch, bits 4:2 are prot_level, and bits 7:5 are 0. A fresh status byte repeats for as long as chip select stays low, so the flag can be polled within a single frame.
- R4: A frame of opcode 0xD8 followed by exactly three address bytes (24 bits, MSB first) starts an erase of sector address[21:16] with erase_all = 0. The erase holds erase_busy high for exactly ERASE_CYCLES clock cycles, pulses erase_done in the last of them, and keeps the target stable throughout.
- R5: A one-byte frame of opcode 0xC7 starts an erase with erase_all = 1, but only when prot_level is 0.
- R6: A frame whose chip select rises mid-byte, or after the wrong number of bytes, is discarded and leaves the write-enable latch unchanged.
- R7: An erase frame received while the write-enable latch is 0 starts no erase.
- R8: With prot_level = p > 0, the top 2^(p-1) of the 64 sectors are locked (p = 7 locks all). A sector erase into a locked sector, or a bulk erase with p != 0, is ignored, and the write-enable latch stays set.
- R9: Starting an erase clears the write-enable latch. The write-in-progress flag reads 1 for the whole erase and 0 once it ends.
- R10: While an erase runs, write-enable and erase frames are ignored.
- R11: spi_so_oe is 1 only while status data is being shifted out in a read-status frame. SO changes after falling SCK.
- R12: All commands work with SCK idling low (mode 0) and idling high (mode 3). SI is sampled on rising SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_si | input | 1 | SPI serial data in |
| spi_so | output | 1 | SPI serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so (0 = high impedance) |
| prot_level | input | 3 | Block-protect level reported in status and used for gating |
| erase_busy | output | 1 | Erase in progress toward the array |
| erase_sector | output | 6 | Sector index of the running sector erase |
| erase_all | output | 1 | Running erase covers the whole array |
| erase_done | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
The assertions rely on the SPI pins changing several system clocks apart, so that the synchronizers see every SCK edge and SI is settled before each rising edge. The bench keeps every SCK half-period at six system clocks and drives the pins only on falling system-clock edges. The checks on protection read prot_level as it was in the cycle the erase was committed. The bench only changes prot_level while chip select is high and no frame is closing. Mode 0 and mode 3 frames are mixed, and chip select is released mid-byte or after too few or too many bytes.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int SEC_W   = 6;
    localparam int NSEC    = 1 << SEC_W;
    localparam int FADDR_W = 24;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_SE   = 8'hD8;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef struct packed {
        logic [2:0]         bit_cnt;
        logic [2:0]         byte_cnt;
        logic [7:0]         sh;
        logic [7:0]         opcode;
        logic [FADDR_W-1:0] addr;
        logic               wel;
        logic               rd_mode;
        logic [SEC_W-1:0]   tgt_sec;
        logic               tgt_all;
    } ctl_t;

    function automatic logic sector_locked(input logic [2:0] bp, input logic [SEC_W-1:0] sec);
        logic [SEC_W:0] span;
        logic [SEC_W:0] first;
        if (bp == 3'd0) return 1'b0;
        span = (SEC_W+1)'(1) << (bp - 3'd1);
        if (span > (SEC_W+1)'(NSEC)) span = (SEC_W+1)'(NSEC);
        first = (SEC_W+1)'(NSEC) - span;
        return {1'b0, sec} >= first;
    endfunction

endpackage

// File: rtl/fe_sync_edge.sv
module fe_sync_edge #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [2:0] st_d, st_q;
        always_comb st_d = {st_q[1:0], din[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= {3{RST_VAL[i]}};
            else        st_q <= st_d;
        end
        assign lvl[i]  = st_q[1];
        assign rise[i] = st_q[1] & ~st_q[2];
        assign fall[i] = ~st_q[1] & st_q[2];
    end
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer #(
    parameter int CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
        else if (start)   cnt_d = CNT_W'(CYCLES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fe_status_tx.sv
module fe_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic       load,
    input  logic [7:0] status,
    input  logic       shift,
    output logic       so,
    output logic       oe
);
    typedef struct packed {
        logic [7:0] sh;
        logic       armed;
        logic       so;
        logic       oe;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        if (cs_s) begin
            d.armed = 1'b0;
            d.oe    = 1'b0;
        end else begin
            if (load) begin
                d.sh    = status;
                d.armed = 1'b1;
            end else if (shift && q.armed) begin
                d.so = q.sh[7];
                d.sh = {q.sh[6:0], 1'b0};
                d.oe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign so = q.so;
    assign oe = q.oe;
endmodule

// File: rtl/fe_erase_target.sv
module fe_erase_target
    import fe_pkg::*;
#(
    parameter int ERASE_CYCLES = 4096,
    parameter int SEC_LSB      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_si,
    output logic             spi_so,
    output logic             spi_so_oe,
    input  logic [2:0]       prot_level,
    output logic             erase_busy,
    output logic [SEC_W-1:0] erase_sector,
    output logic             erase_all,
    output logic             erase_done
);
    logic [2:0] lvl, rise, fall;
    logic       cs_s, si_s, sck_rise, sck_fall, cs_rise;
    logic       start, load_status, busy, wel_w;
    logic [7:0] new_byte, status;
    ctl_t       d, q;

    fe_sync_edge #(.WIDTH(3), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({spi_si, spi_sck, spi_cs_n}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign cs_s     = lvl[0];
    assign si_s     = lvl[2];
    assign cs_rise  = rise[0];
    assign sck_rise = rise[1] & ~cs_s;
    assign sck_fall = fall[1] & ~cs_s;
    assign new_byte = {q.sh[6:0], si_s};

    always_comb begin
        d           = q;
        start       = 1'b0;
        load_status = 1'b0;
        if (cs_s) begin
            d.bit_cnt  = '0;
            d.byte_cnt = '0;
            d.rd_mode  = 1'b0;
        end else if (sck_rise) begin
            d.sh      = new_byte;
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                if (q.byte_cnt != 3'd7) d.byte_cnt = q.byte_cnt + 3'd1;
                if (q.byte_cnt == 3'd0) begin
                    d.opcode = new_byte;
                    if (new_byte == OP_RDSR) d.rd_mode = 1'b1;
                end else begin
                    d.addr = {q.addr[FADDR_W-9:0], new_byte};
                end
                load_status = q.rd_mode || (q.byte_cnt == 3'd0 && new_byte == OP_RDSR);
            end
        end
        if (cs_rise && q.bit_cnt == 3'd0 && !busy) begin
            unique case (q.opcode)
                OP_WREN: if (q.byte_cnt == 3'd1) d.wel = 1'b1;
                OP_SE: if (q.byte_cnt == 3'd4 && q.wel &&
                           !sector_locked(prot_level, q.addr[SEC_LSB +: SEC_W])) begin
                    start     = 1'b1;
                    d.tgt_sec = q.addr[SEC_LSB +: SEC_W];
                    d.tgt_all = 1'b0;
                end
                OP_BE: if (q.byte_cnt == 3'd1 && q.wel && prot_level == 3'd0) begin
                    start     = 1'b1;
                    d.tgt_sec = '0;
                    d.tgt_all = 1'b1;
                end
                default: ;
            endcase
            if (start) d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    fe_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(erase_done)
    );

    assign status = {3'b000, prot_level, q.wel, busy};

    fe_status_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .load(load_status),
        .status(status), .shift(sck_fall), .so(spi_so), .oe(spi_so_oe)
    );

    assign wel_w        = q.wel;
    assign erase_busy   = busy;
    assign erase_sector = q.tgt_sec;
    assign erase_all    = q.tgt_all;
endmodule

// File: rtl/fe_erase_target_chk.sv
module fe_erase_target_chk
    import fe_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             wel,
    input logic [2:0]       prot_level,
    input logic             erase_busy,
    input logic [SEC_W-1:0] erase_sector,
    input logic             erase_all,
    input logic             erase_done,
    input logic             spi_so_oe
);
    logic [2:0]       prot_prev_q;
    logic [SEC_W-1:0] low_mask;
    logic             hit_locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_prev_q <= '0;
        else        prot_prev_q <= prot_level;
    end

    always_comb begin
        low_mask   = (prot_prev_q == 3'd0) ? '0 :
                     SEC_W'((64'(1) << (prot_prev_q - 3'd1)) - 64'(1));
        hit_locked = (prot_prev_q != 3'd0) && (&(erase_sector | low_mask));
    end

    assert_done_inside_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> erase_busy);
    assert_idle_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> !erase_busy);
    assert_target_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && $past(erase_busy)) |-> ($stable(erase_sector) && $stable(erase_all)));
    assert_bulk_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(erase_busy) && erase_all) |-> (prot_prev_q == 3'd0));
    assert_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> $past(wel));
    assert_sector_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(erase_busy) && !erase_all) |-> !hit_locked);
    assert_wel_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> !wel);
    assert_wel_held_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && $past(erase_busy)) |-> !wel);
    assert_oe_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_so_oe);
endmodule

bind fe_erase_target fe_erase_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .wel(wel_w), .prot_level(prot_level),
    .erase_busy(erase_busy), .erase_sector(erase_sector), .erase_all(erase_all),
    .erase_done(erase_done), .spi_so_oe(spi_so_oe)
);

// File: tb/tb_fe_erase_target.sv
module tb_fe_erase_target;
    localparam int EC = 800;
    localparam int H  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic [2:0] prot = 3'd0;
    logic       so, so_oe, busy, all, done;
    logic [5:0] sector;

    always #10 clk = ~clk;

    fe_erase_target #(.ERASE_CYCLES(EC)) dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .prot_level(prot), .erase_busy(busy),
        .erase_sector(sector), .erase_all(all), .erase_done(done)
    );

    int   checks = 0, fails = 0;
    bit   mode3 = 1'b0;
    bit   exp_pending = 1'b0;
    logic [5:0] exp_sec;
    bit   exp_all;
    int   mcnt = 0;
    logic prev_busy = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model of the erase request, compared on every clock (R4, R5, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                if (!exp_pending) begin
                    check(0, "R10", "unexpected erase start", 1, 0);
                end else begin
                    check(sector == exp_sec && all == exp_all, "R4", "erase target",
                          {all, sector}, {exp_all, exp_sec});
                    exp_pending = 1'b0;
                    mcnt = EC;
                end
            end
            if (mcnt > 0) begin
                if (!busy || done != (mcnt == 1)) begin
                    fails++;
                    $display("FAIL R4 busy/done at countdown %0d: actual %0d/%0d expected 1/%0d",
                             mcnt, busy, done, mcnt == 1);
                end
                mcnt--;
            end else if (busy || done) begin
                fails++;
                $display("FAIL R4 busy/done outside erase: actual %0d/%0d expected 0/0", busy, done);
            end
            prev_busy = busy;
        end
    end

    task automatic spi_open();
        sck  = mode3;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic spi_bits(input logic [7:0] b, input int n, output logic [7:0] got,
                            output bit oe_all, output bit oe_any);
        got = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 0; i < n; i++) begin
            sck = 1'b0;
            si  = b[7-i];
            tick(H);
            got[7-i] = so;
            oe_all &= so_oe;
            oe_any |= so_oe;
            sck = 1'b1;
            tick(H);
        end
    endtask

    task automatic spi_close();
        if (!mode3) begin
            sck = 1'b0;
            tick(H);
        end
        cs_n = 1'b1;
        tick(3*H);
    endtask

    task automatic frame(input logic [7:0] op, input int nadr, input logic [23:0] addr,
                         input int tail);
        logic [7:0] g; bit a, y;
        spi_open();
        spi_bits(op, 8, g, a, y);
        check(!y, "R11", "oe while host sends", y, 0);
        for (int k = 0; k < nadr; k++) spi_bits(addr[23-8*(k%3) -: 8], 8, g, a, y);
        if (tail > 0) spi_bits(8'hA5, tail, g, a, y);
        spi_close();
    endtask

    task automatic read_status(input int n, input logic [7:0] exp, input string req);
        logic [7:0] g; bit a, y;
        spi_open();
        spi_bits(8'h05, 8, g, a, y);
        check(!y, "R11", "oe during read opcode", y, 0);
        for (int k = 0; k < n; k++) begin
            spi_bits(8'h00, 8, g, a, y);
            check(g == exp, req, "status byte", g, exp);
            check(a, "R11", "oe while shifting status", a, 1);
        end
        spi_close();
        check(!so_oe, "R11", "oe after frame", so_oe, 0);
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 4*EC) begin tick(1); t++; end
        tick(5);
        check(!exp_pending, "R4", "expected erase occurred", exp_pending, 0);
    endtask

    task automatic expect_erase(input logic [5:0] s, input bit a);
        exp_sec = s; exp_all = a; exp_pending = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        check(!busy && !done && !so_oe, "R1", "outputs after reset", {busy, done, so_oe}, 0);
        read_status(1, 8'h00, "R1");

        // R2 write enable, R3 format
        frame(8'h06, 0, 24'h0, 0);
        read_status(1, 8'h02, "R2");

        // R4 sector erase; R9 WIP during; R3 repeated poll; R10 WREN ignored
        expect_erase(6'h2A, 1'b0);
        frame(8'hD8, 3, 24'h2A1234, 0);
        read_status(2, 8'h01, "R9");
        frame(8'h06, 0, 24'h0, 0);
        frame(8'hC7, 0, 24'h0, 0);
        read_status(1, 8'h01, "R10");
        wait_idle();
        read_status(1, 8'h00, "R9");

        // R7 erase without write enable
        frame(8'hC7, 0, 24'h0, 0);
        frame(8'hD8, 3, 24'h050000, 0);
        tick(20);
        check(!busy, "R7", "busy without WEL", busy, 0);

        // R6 framing errors keep WEL
        frame(8'h06, 0, 24'h0, 0);
        frame(8'hD8, 3, 24'h050000, 4);
        frame(8'hD8, 2, 24'h050000, 0);
        frame(8'hD8, 4, 24'h050000, 0);
        frame(8'hC7, 0, 24'h0, 3);
        tick(20);
        check(!busy, "R6", "busy after bad frames", busy, 0);
        read_status(1, 8'h02, "R6");

        // R8 protection, R12 mode 3
        prot = 3'd1;
        frame(8'hD8, 3, 24'h3F0000, 0);
        tick(20);
        check(!busy, "R8", "locked sector erased", busy, 0);
        read_status(1, 8'h06, "R8");
        mode3 = 1'b1;
        expect_erase(6'h3E, 1'b0);
        frame(8'hD8, 3, 24'hFEABCD, 0);
        read_status(1, 8'h05, "R12");
        wait_idle();

        prot = 3'd3;
        frame(8'h06, 0, 24'h0, 0);
        frame(8'hD8, 3, 24'h3C0000, 0);
        frame(8'hC7, 0, 24'h0, 0);
        tick(20);
        check(!busy, "R8", "bulk/locked with prot 3", busy, 0);
        read_status(1, 8'h0E, "R8");

        // R5 bulk erase in mode 3
        prot = 3'd0;
        expect_erase(6'h00, 1'b1);
        frame(8'hC7, 0, 24'h0, 0);
        read_status(2, 8'h01, "R5");
        wait_idle();

        // R4 sector index from address bits 21:16, mode 0
        mode3 = 1'b0;
        frame(8'h06, 0, 24'h0, 0);
        expect_erase(6'h05, 1'b0);
        frame(8'hD8, 3, 24'hC5FFFF, 0);
        wait_idle();
        read_status(1, 8'h00, "R4");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule